// File: doc/BRIEF.md
# Serial Gain Chain Loader

This block holds one 8-bit gain value for each of sixteen channels. On command it shifts all of them into a daisy chain of eight dual digital potentiometers. Each chip in the chain takes a 17-bit frame. The frame opens with a stack-select bit, which is always sent as zero so that the two wipers of the chip stay independent. The two gains of the chip's channel pair follow.

The chain is loaded over three lines: a data line, a serial clock that idles low, and an enable line. The enable line is the active-low reset/latch input of the potentiometers. It rises before the first bit and stays high for the whole 136-bit transfer, and its falling edge commits every wiper at once. Because of that framing, a change to any single gain still needs all sixteen gains to be resent.

Host logic writes gains through a narrow address/data port. It sets the serial clock rate with a half-period count, pulses `start`, and waits for `done`.

Top module: `gain_chain_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done`, `chain_en`, `ser_clk` and `ser_data` are all 0.
- R2: A cycle with `wr_en` high while idle stores `wr_data` as the gain of channel `wr_addr` (4-bit address, channel 0 to 15). The next transfer carries that value.
- R3: A write presented while `busy` is high has no effect; the following transfer carries the old value.
- R4: When `start` is sampled high while idle, `busy` and `chain_en` go high in the next cycle, with `ser_clk` low and the first bit on `ser_data`.
- R5: A transfer is 136 bits: eight 17-bit frames. Frame position 0 is a 0 bit. Positions 1 to 8 are the higher channel of the pair, MSB first. Positions 9 to 16 are the lower channel, MSB first.
- R6: Frames go out in descending channel order: frame 0 carries channels 15 and 14, frame 1 carries channels 13 and 12, and so on, down to frame 7, which carries channels 1 and 0.
- R7: For each bit, with H the half-period: `ser_clk` is low for H cycles with the new bit on `ser_data`, then high for H cycles. Between two bits there is one further low cycle in which the old bit is still held. `ser_data` never changes while `ser_clk` is high, nor on its falling edge.
- R8: `half_period` is sampled when a transfer starts and held for the rest of it. A value of 0 acts as 1.
- R9: After the last rising edge, `ser_clk` stays low for H more cycles. Then `chain_en` and `busy` fall together, and `done` is high for exactly that one cycle.
- R10: A `start` pulse while `busy` is high is ignored and does not extend or restart the transfer.
- R11: Whenever the block is idle, `ser_clk`, `chain_en` and `ser_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Gain write strobe |
| wr_addr | input | 4 | Channel number of the write |
| wr_data | input | 8 | Gain value to store |
| half_period | input | 8 | Serial clock half-period in system clocks (0 acts as 1) |
| start | input | 1 | Begin a full chain load |
| busy | output | 1 | High from the cycle after start until the enable falls |
| done | output | 1 | One-cycle pulse when the enable falls |
| ser_data | output | 1 | Serial data to the chain |
| ser_clk | output | 1 | Serial clock to the chain, idles low |
| chain_en | output | 1 | Active-low reset/latch line of the chain; high for the whole transfer |

## Verification
The assertions assume that the whole transfer happens under one reset. The data and timing checks also assume that only the block drives the three chain lines, so a rising clock edge always marks a bit that the block itself produced.

The frame-position check relies on each transfer starting from an idle block. The bench therefore issues `start` only while idle, or deliberately while busy to exercise R10. It waits for `done` and the return to idle before it writes new gains or starts the next load.

Half-periods of 0, 1, 2 and 3 are used, so the stimulus stays within short divider counts.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_HOLD,
        ST_TAIL
    } seq_state_e;
endpackage

// File: rtl/gcl_gain_regs.sv
module gcl_gain_regs #(
    parameter int NUM_CHAN = 16,
    parameter int GAIN_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_CHAN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [GAIN_W-1:0]          wr_data,
    output logic [NUM_CHAN*GAIN_W-1:0] gains_flat
);
    logic [GAIN_W-1:0] gain_d [NUM_CHAN];
    logic [GAIN_W-1:0] gain_q [NUM_CHAN];

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        always_comb begin
            gain_d[c] = gain_q[c];
            if (wr_en && (wr_addr == ADDR_W'(c))) begin
                gain_d[c] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gain_q[c] <= '0;
            else        gain_q[c] <= gain_d[c];
        end

        assign gains_flat[c*GAIN_W +: GAIN_W] = gain_q[c];
    end
endmodule

// File: rtl/gcl_bit_select.sv
module gcl_bit_select #(
    parameter int NUM_CHAN = 16,
    parameter int GAIN_W   = 8,
    parameter int CHIP_W   = 3,
    parameter int POS_W    = 5,
    localparam int IDX_W   = $clog2(NUM_CHAN*GAIN_W)
) (
    input  logic [NUM_CHAN*GAIN_W-1:0] gains_flat,
    input  logic [CHIP_W-1:0]          chip,
    input  logic [POS_W-1:0]           pos,
    output logic                       bit_o
);
    int                 hi_ch;
    logic [IDX_W-1:0]   idx;

    always_comb begin
        hi_ch = NUM_CHAN - 1 - 2*int'(chip);
        idx   = '0;
        bit_o = 1'b0;
        if (pos == '0) begin
            bit_o = 1'b0;                       // stack-select, always zero
        end else if (int'(pos) <= GAIN_W) begin
            idx   = IDX_W'(hi_ch*GAIN_W + GAIN_W - int'(pos));
            bit_o = gains_flat[idx];
        end else begin
            idx   = IDX_W'((hi_ch-1)*GAIN_W + 2*GAIN_W - int'(pos));
            bit_o = gains_flat[idx];
        end
    end
endmodule

// File: rtl/gcl_phase_timer.sv
module gcl_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] limit,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign expire = (cnt_q == limit - 1'b1);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clear || expire) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gain_chain_loader.sv
module gain_chain_loader
    import gcl_pkg::*;
#(
    parameter int NUM_CHAN = 16,
    parameter int GAIN_W   = 8,
    parameter int DIV_W    = 8,
    localparam int ADDR_W     = $clog2(NUM_CHAN),
    localparam int NUM_CHIPS  = NUM_CHAN / 2,
    localparam int FRAME_BITS = 2*GAIN_W + 1,
    localparam int TOTAL_BITS = NUM_CHIPS * FRAME_BITS,
    localparam int CNT_W      = $clog2(TOTAL_BITS),
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int CHIP_W     = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [GAIN_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              chain_en
);
    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   bit_cnt;
        logic [CHIP_W-1:0]  chip;
        logic [POS_W-1:0]   pos;
        logic [DIV_W-1:0]   hp;
        logic               en;
        logic               sclk;
        logic               data;
        logic               busy;
        logic               done;
    } seq_t;

    seq_t s_d, s_q;
    logic [NUM_CHAN*GAIN_W-1:0] gains_flat;
    logic sel_bit, tmr_clear, tmr_expire;

    gcl_gain_regs #(.NUM_CHAN(NUM_CHAN), .GAIN_W(GAIN_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en && !s_q.busy),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .gains_flat (gains_flat)
    );

    gcl_bit_select #(
        .NUM_CHAN(NUM_CHAN), .GAIN_W(GAIN_W), .CHIP_W(CHIP_W), .POS_W(POS_W)
    ) i_sel (
        .gains_flat (gains_flat),
        .chip       (s_q.chip),
        .pos        (s_q.pos),
        .bit_o      (sel_bit)
    );

    gcl_phase_timer #(.DIV_W(DIV_W)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .limit  (s_q.hp),
        .expire (tmr_expire)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        tmr_clear = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st      = ST_SETUP;
                    s_d.en      = 1'b1;
                    s_d.busy    = 1'b1;
                    s_d.sclk    = 1'b0;
                    s_d.data    = sel_bit;
                    s_d.hp      = (half_period == '0) ? DIV_W'(1) : half_period;
                    s_d.bit_cnt = '0;
                    tmr_clear   = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_expire) begin
                    s_d.st   = ST_HIGH;
                    s_d.sclk = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_expire) begin
                    s_d.sclk = 1'b0;
                    if (s_q.bit_cnt == CNT_W'(TOTAL_BITS-1)) begin
                        s_d.st = ST_TAIL;
                    end else begin
                        s_d.st      = ST_HOLD;
                        s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                        if (s_q.pos == POS_W'(FRAME_BITS-1)) begin
                            s_d.pos  = '0;
                            s_d.chip = s_q.chip + 1'b1;
                        end else begin
                            s_d.pos = s_q.pos + 1'b1;
                        end
                    end
                end
            end
            ST_HOLD: begin
                s_d.st    = ST_SETUP;
                s_d.data  = sel_bit;
                tmr_clear = 1'b1;
            end
            ST_TAIL: begin
                if (tmr_expire) begin
                    s_d.st      = ST_IDLE;
                    s_d.en      = 1'b0;
                    s_d.busy    = 1'b0;
                    s_d.done    = 1'b1;
                    s_d.data    = 1'b0;
                    s_d.bit_cnt = '0;
                    s_d.chip    = '0;
                    s_d.pos     = '0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
            s_q.hp <= DIV_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign ser_data = s_q.data;
    assign ser_clk  = s_q.sclk;
    assign chain_en = s_q.en;
endmodule

// File: rtl/gcl_checker.sv
module gcl_checker #(
    parameter int FRAME_BITS = 17,
    parameter int NUM_CHIPS  = 8,
    localparam int TOTAL_BITS = FRAME_BITS * NUM_CHIPS
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic chain_en,
    input logic ser_clk,
    input logic ser_data
);
    logic sclk_prev;
    int   frame_pos;
    int   rise_total;
    logic rise;

    assign rise = ser_clk && !sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b0;
            frame_pos  <= 0;
            rise_total <= 0;
        end else begin
            sclk_prev <= ser_clk;
            if (!busy) begin
                frame_pos  <= 0;
                rise_total <= 0;
            end else if (rise) begin
                frame_pos  <= (frame_pos == FRAME_BITS-1) ? 0 : frame_pos + 1;
                rise_total <= rise_total + 1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !chain_en)); // R11
    AST_EN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> chain_en); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_en) |-> (done && !busy)); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk || $fell(ser_clk)) |-> $stable(ser_data)); // R7
    AST_STACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && frame_pos == 0) |-> !ser_data); // R5
    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_en) |-> (rise_total == TOTAL_BITS)); // R5
endmodule

bind gain_chain_loader gcl_checker i_gcl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .chain_en (chain_en),
    .ser_clk  (ser_clk),
    .ser_data (ser_data)
);

// File: tb/test_gain_chain_loader.sv
module test_gain_chain_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] half_period = 8'd1;
    logic       start = 1'b0;
    logic       busy, done, ser_data, ser_clk, chain_en;

    always #5 clk = ~clk;

    gain_chain_loader i_gain_chain_loader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .half_period(half_period), .start(start),
        .busy(busy), .done(done), .ser_data(ser_data), .ser_clk(ser_clk),
        .chain_en(chain_en)
    );

    typedef struct packed {
        logic en; logic sclk; logic data; logic bsy; logic dn;
    } exp_t;

    exp_t       q[$];
    exp_t       cur = '0;
    logic [7:0] gm [16];
    string      scen = "R1";
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    logic       pb;

    // Bit k of a full load, built from the frame rules (R5, R6)
    function automatic logic stream_bit(int k);
        int frame = k / 17;
        int p     = k % 17;
        int hi    = 15 - 2*frame;
        if (p == 0) return 1'b0;
        if (p <= 8) return gm[hi][8-p];
        return gm[hi-1][16-p];
    endfunction

    task automatic push_transfer(int h);
        logic b;
        for (int k = 0; k < 136; k++) begin
            b = stream_bit(k);
            for (int i = 0; i < h; i++) q.push_back('{1'b1, 1'b0, b, 1'b1, 1'b0});
            for (int i = 0; i < h; i++) q.push_back('{1'b1, 1'b1, b, 1'b1, 1'b0});
            if (k < 135) q.push_back('{1'b1, 1'b0, b, 1'b1, 1'b0});
        end
        b = stream_bit(135);
        for (int i = 0; i < h; i++) q.push_back('{1'b1, 1'b0, b, 1'b1, 1'b0});
        q.push_back('{1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
    endtask

    // Reference model, stepped on every clock
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete();
            cur = '0;
        end else begin
            pb = cur.bsy;
            if (wr_en && !pb) gm[wr_addr] = wr_data;
            if (start && !pb) push_transfer((half_period == 0) ? 1 : int'(half_period));
            if (q.size() > 0) cur = q.pop_front();
            else              cur = '0;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s (%s) at cycle %0d: actual %b expected %b",
                     scen, req, what, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4",  "busy",     busy,     cur.bsy);
            chk("R9",  "done",     done,     cur.dn);
            chk("R11", "chain_en", chain_en, cur.en);
            chk("R7",  "ser_clk",  ser_clk,  cur.sclk);
            chk("R5",  "ser_data", ser_data, cur.data);
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    task automatic write_gain(int ch, logic [7:0] v);
        wr_en = 1'b1; wr_addr = 4'(ch); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (cur.bsy || q.size() > 0);
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 16; c++) gm[c] = '0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        chk("R1", "busy",     busy,     1'b0);
        chk("R1", "done",     done,     1'b0);
        chk("R1", "chain_en", chain_en, 1'b0);
        chk("R1", "ser_clk",  ser_clk,  1'b0);
        chk("R1", "ser_data", ser_data, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: load a distinct gain per channel, then a fast load (R4, R6)
        scen = "R2";
        for (int c = 0; c < 16; c++) write_gain(c, 8'(c*37 + 11));
        scen = "R6";
        half_period = 8'd1;
        pulse_start();
        wait_idle();

        // R8: zero half-period behaves as one, alternating bit pattern
        scen = "R8";
        for (int c = 0; c < 16; c++) write_gain(c, (c % 2 == 0) ? 8'hA5 : 8'h5A);
        half_period = 8'd0;
        pulse_start();
        wait_idle();

        // R10 and R3: start, write and divider change while busy
        scen = "R10";
        half_period = 8'd3;
        pulse_start();
        half_period = 8'd1;          // R8: must not affect the running load
        repeat (20) @(negedge clk);
        pulse_start();               // R10: ignored
        write_gain(5, 8'h00);        // R3: ignored
        write_gain(14, 8'hFF);       // R3: ignored
        wait_idle();

        // R3: next load still carries the old values of channels 5 and 14
        scen = "R3";
        half_period = 8'd2;
        pulse_start();
        wait_idle();

        // R11: stays quiet while idle
        scen = "R11";
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule